// File: doc/BRIEF.md
# Gated 3-to-8 Line Decoder

This block turns a 3-bit select code into eight active-low lines. Exactly one line, the one whose index equals the select code, is pulled low, but only while the decoder is enabled. Enabling takes three qualifying inputs at once: two that are asserted low and one that is asserted high. If any of the three is deasserted, all eight lines stay high and the select code is ignored.

The logic is purely combinational and holds no state. The mixed-polarity enables let two instances be chained into a 4-to-16 decoder with no extra gates. The top select bit drives the low-true enable of one instance and the high-true enable of the other. A shared low-true enable then gates the whole group.

Top module: `gated_dec3to8`

## Requirements
- R1: With `en1_n`=0, `en2_n`=0 and `en3`=1, `y_n[k]` is 0 for k equal to the unsigned value of `sel`, and every other bit of `y_n` is 1 (for example, `sel`=000 gives `y_n`=8'b1111_1110).
- R2: With `en1_n`=1, `y_n` is 8'hFF for every value of `sel` and of the other enables.
- R3: With `en2_n`=1, `y_n` is 8'hFF for every value of `sel` and of the other enables.
- R4: With `en3`=0, `y_n` is 8'hFF for every value of `sel` and of the other enables.
- R5: At most one bit of `y_n` is 0 at any time.
- R6: Exactly one bit of `y_n` is 0 when the three enables are asserted, and none is 0 otherwise.
- R7: Two instances form a 4-to-16 decoder with a 4-bit code c and a group enable g_n. The low instance takes c[2:0] as select, c[3] on `en1_n`, g_n on `en2_n` and 1 on `en3`. The high instance takes c[2:0] as select, 0 on `en1_n`, g_n on `en2_n` and c[3] on `en3`. The 16 outputs {high,low} are then all 1 except bit c, which is 0 when g_n=0.
- R8: The output depends only on the present inputs. The same inputs give the same `y_n` whatever was applied before, and a change shows up with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 3 | Select code naming the line to drive low |
| en1_n | input | 1 | Enable, asserted at 0 |
| en2_n | input | 1 | Enable, asserted at 0 |
| en3 | input | 1 | Enable, asserted at 1 |
| y_n | output | 8 | Decoded lines, active low |

## Verification
The bench applies all 64 pairings of select code and enable state. A design that decodes only the all-asserted enable pattern, or inverts the polarity of one enable, fails on the single-enable-deasserted cases. A design that drives active-high outputs, or swaps line order, fails on the first enabled select code. The bench also drives the two-instance 4-to-16 chain through every code with the group enable on and off. A design whose disabled state leaves any line low lights two lines in the chain. Replaying the same inputs after a different history exposes any hidden storage.

// File: rtl/gated_dec_pkg.sv
`timescale 1ns/1ps
package gated_dec_pkg;
  localparam int unsigned DEC_SEL_W = 3;

  // All three qualifiers must be asserted together.
  function automatic logic dec_enabled(input logic low_a, input logic low_b,
                                       input logic high_c);
    return (~low_a) & (~low_b) & high_c;
  endfunction
endpackage

// File: rtl/gated_dec_enable.sv
`timescale 1ns/1ps
module gated_dec_enable (
  input  logic en1_n,
  input  logic en2_n,
  input  logic en3,
  output logic en_ok
);
  import gated_dec_pkg::*;

  assign en_ok = dec_enabled(en1_n, en2_n, en3);

  always_comb begin
    if (en1_n) a_r2_low1_blocks: assert (!en_ok);
    if (en2_n) a_r3_low2_blocks: assert (!en_ok);
    if (!en3)  a_r4_high_blocks: assert (!en_ok);
  end
endmodule

// File: rtl/gated_dec_onehot.sv
`timescale 1ns/1ps
module gated_dec_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_N-1:0] hot
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    a_r5_single_hot: assert ($onehot0(hot));
  end
endmodule

// File: rtl/gated_dec_drive.sv
`timescale 1ns/1ps
module gated_dec_drive #(
  parameter int unsigned OUT_N = 8
) (
  input  logic [OUT_N-1:0] hot,
  input  logic             en_ok,
  output logic [OUT_N-1:0] y_n
);
  assign y_n = ~(hot & {OUT_N{en_ok}});
endmodule

// File: rtl/gated_dec3to8.sv
`timescale 1ns/1ps
module gated_dec3to8 #(
  parameter int unsigned SEL_W = gated_dec_pkg::DEC_SEL_W,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en1_n,
  input  logic             en2_n,
  input  logic             en3,
  output logic [OUT_N-1:0] y_n
);
  logic             en_ok;
  logic [OUT_N-1:0] hot;

  gated_dec_enable u_en (
    .en1_n (en1_n),
    .en2_n (en2_n),
    .en3   (en3),
    .en_ok (en_ok)
  );

  gated_dec_onehot #(.SEL_W(SEL_W)) u_hot (
    .sel (sel),
    .hot (hot)
  );

  gated_dec_drive #(.OUT_N(OUT_N)) u_drv (
    .hot   (hot),
    .en_ok (en_ok),
    .y_n   (y_n)
  );

  always_comb begin
    a_r5_at_most_one_low: assert ($countones(~y_n) <= 1);
    a_r6_low_iff_enabled: assert (((~y_n) != '0) == en_ok);
    if (en_ok) a_r1_selected_low: assert (y_n[sel] == 1'b0);
    else       a_r4_idle_high: assert (&y_n);
  end
endmodule

// File: tb/gated_dec3to8_tb.sv
`timescale 1ns/1ps
module gated_dec3to8_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] sel;
  logic       en1_n, en2_n, en3;
  logic [7:0] y_n;

  logic [3:0]  code;
  logic        grp_n;
  logic [15:0] wide_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gated_dec3to8 u_dut (.sel(sel), .en1_n(en1_n), .en2_n(en2_n), .en3(en3), .y_n(y_n));

  gated_dec3to8 u_lo (.sel(code[2:0]), .en1_n(code[3]), .en2_n(grp_n), .en3(1'b1),
                      .y_n(wide_n[7:0]));
  gated_dec3to8 u_hi (.sel(code[2:0]), .en1_n(1'b0), .en2_n(grp_n), .en3(code[3]),
                      .y_n(wide_n[15:8]));

  // Behavioural reference: integers, no gate structure.
  function automatic logic [15:0] ref_lines(input int idx, input int width, input bit on);
    logic [15:0] v;
    v = '1;
    for (int k = 0; k < width; k++) if (on && k == idx) v[k] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input int s, input bit a, input bit b, input bit c);
    @(posedge clk);
    sel = 3'(s); en1_n = a; en2_n = b; en3 = c;
    @(negedge clk);
  endtask

  initial begin
    sel = '0; en1_n = 1'b1; en2_n = 1'b1; en3 = 1'b0;
    code = '0; grp_n = 1'b1;
    @(negedge clk);
    check("R4 idle state", {8'h00, y_n}, 16'h00FF);

    // R1..R6: every select with every enable pattern
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        bit a, b, c, on;
        string req;
        a = e[0]; b = e[1]; c = e[2];
        on = (a == 0) && (b == 0) && (c == 1);
        drive(s, a, b, c);
        if (on)      req = "R1 enabled decode";
        else if (a)  req = "R2 en1_n high";
        else if (b)  req = "R3 en2_n high";
        else         req = "R4 en3 low";
        check(req, {8'h00, y_n}, {8'h00, ref_lines(s, 8, on)[7:0]});
        check("R5 R6 low count", 16'($countones(~y_n)), on ? 16'd1 : 16'd0);
      end
    end

    // R8: same inputs after different history
    drive(5, 0, 0, 1);
    drive(2, 1, 0, 1);
    drive(5, 0, 0, 1);
    check("R8 no history", {8'h00, y_n}, {8'h00, ref_lines(5, 8, 1)[7:0]});
    @(posedge clk);
    #1 sel = 3'd6;
    #0.5 check("R8 follows without edge", {8'h00, y_n}, {8'h00, ref_lines(6, 8, 1)[7:0]});

    // R7: cascade into 4-to-16
    for (int g = 0; g < 2; g++) begin
      for (int cv = 0; cv < 16; cv++) begin
        @(posedge clk);
        code = 4'(cv); grp_n = g[0];
        @(negedge clk);
        check("R7 cascade", wide_n, ref_lines(cv, 16, g == 0));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule